// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit down-counting channel of a PC-style interval timer. It is driven by a single-cycle count-enable tick, and each tick stands for one period of the 1.19318 MHz timer input. A control-word decoder sits in front of the channel. It takes commands addressed to this channel, which set the mode or latch the count. It ignores commands for the other channels and raises a sticky error flag on any command the channel cannot carry out.

Software loads and reads the 16-bit count through an 8-bit data port, low byte first and then the high byte. Loads and reads keep separate byte pointers. A latch command freezes a snapshot of the count, and that snapshot is read back in place of the live count until both of its bytes have been taken.

The channel drives one output pin. The pin rises at terminal count in mode 0 and keeps its level through expiry in modes 2 and 3. The output level is also reported as the speaker bit of a port-B status byte.

Top module: `interval_timer_chan`

## Requirements
- R1: After reset the output pin, the error flag and the port-B status byte are all 0, and reading the data port twice returns 0x00 then 0x00 (low byte, then high byte).
- R2: A data-port write to the low byte does four things: it replaces count bits 7:0, stops any countdown, forces the output low, and points the next write at the high byte.
- R3: A data-port write to the high byte replaces count bits 15:8 and stores the resulting 16-bit count as the period. Counting begins only if that period is non-zero. The next write then goes to the low byte.
- R4: While counting, each tick lowers the count by exactly one. Without a tick, the count holds.
- R5: In mode 0, the tick that takes the count from 1 to 0 drives the output high. The count then stays at 0 on later ticks.
- R6: In modes 2 and 3, the tick that would take the count from 1 to 0 instead reloads the period, and the output level does not change.
- R7: A latch command (control bits 5:4 = 00, bits 7:6 = this channel) copies the live count into a holding register and resets the read pointer to the low byte. It has no effect while an earlier snapshot is still unread.
- R8: While a snapshot is pending, reads return its low byte and then its high byte. Reading the high byte releases the snapshot.
- R9: With no snapshot pending, reads return the live count, low byte and high byte in alternation.
- R10: A control word sets the sticky error flag and leaves the mode unchanged if any of these holds: it selects counter 3; or it is addressed to this channel with BCD (bit 0) set, with a mode (bits 3:1) other than 0, 2 or 3, or with access bits 5:4 equal to 01 or 10. A control word addressed to another counter has no effect.
- R11: Bit SPKR_BIT (default 5) of the port-B status byte equals the output pin. All other bits of that byte are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle count-enable (timer input period) |
| wrCtrl | input | 1 | Write strobe for the control-word port |
| wrData | input | 1 | Write strobe for the data port |
| rdData | input | 1 | Read strobe for the data port; consumes the byte on rdByte |
| wrByte | input | 8 | Write data for either port |
| rdByte | output | 8 | Byte that the next data-port read returns |
| timerOut | output | 1 | Channel output pin |
| portBStatus | output | 8 | Port-B status byte carrying the output level |
| cfgError | output | 1 | Sticky error for unsupported control words |

## Verification
The bench builds the channel with CHAN_ID = 1 and the default SPKR_BIT of 5. With CHAN_ID set to 1, control words addressed to counters 0 and 2 become foreign traffic, so the bench can show that a word carrying an illegal mode for another counter neither sets the error flag nor changes this channel's mode. With SPKR_BIT at 5, the port-B check expects exactly 0x20 once mode 0 expires. The mode-retention check sends a rejected BCD word after mode 0 has been selected. It then shows that the count still stops and raises the pin, instead of reloading.

// File: rtl/itc_pkg.sv
package itc_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    MODE_TC   = 3'd0,
    MODE_RATE = 3'd2,
    MODE_SQW  = 3'd3
  } itc_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic snap;
    logic readHold;
    logic readHigh;
  } itc_strobe_t;
endpackage

// File: rtl/itc_ctrl.sv
module itc_ctrl
  import itc_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCtrl,
  input  logic              wrData,
  input  logic              rdData,
  input  logic [BYTE_W-1:0] wrByte,
  output itc_strobe_t       strb,
  output itc_mode_e         mode,
  output logic              cfgError
);
  localparam logic [1:0] SEL_ME   = 2'(CHAN_ID);
  localparam logic [1:0] SEL_RB   = 2'd3;
  localparam logic [1:0] ACC_LAT  = 2'b00;
  localparam logic [1:0] ACC_WORD = 2'b11;

  logic [1:0] cwSel, cwAcc;
  logic [2:0] cwMode;
  logic       cwBcd;
  logic       mine, badSel, badCfg, isLatch, modeOk;
  logic       wrHigh, rdHigh, latchPend;

  assign cwSel  = wrByte[7:6];
  assign cwAcc  = wrByte[5:4];
  assign cwMode = wrByte[3:1];
  assign cwBcd  = wrByte[0];

  assign mine    = (cwSel == SEL_ME);
  assign badSel  = (cwSel == SEL_RB);
  assign modeOk  = (cwMode == MODE_TC) || (cwMode == MODE_RATE) || (cwMode == MODE_SQW);
  assign isLatch = mine && (cwAcc == ACC_LAT);
  assign badCfg  = mine && (cwAcc != ACC_LAT) &&
                   ((cwAcc != ACC_WORD) || cwBcd || !modeOk);

  always_comb begin
    strb          = '0;
    strb.loadLo   = wrData && !wrHigh;
    strb.loadHi   = wrData && wrHigh;
    strb.snap     = wrCtrl && isLatch && !latchPend;
    strb.readHold = latchPend;
    strb.readHigh = rdHigh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode      <= MODE_TC;
      cfgError  <= 1'b0;
      wrHigh    <= 1'b0;
      rdHigh    <= 1'b0;
      latchPend <= 1'b0;
    end else begin
      if (wrCtrl) begin
        if (badSel || badCfg)
          cfgError <= 1'b1;
        else if (mine && cwAcc == ACC_WORD)
          mode <= itc_mode_e'(cwMode);
      end
      if (wrData)
        wrHigh <= !wrHigh;
      if (strb.snap) begin
        latchPend <= 1'b1;
        rdHigh    <= 1'b0;
      end else if (rdData) begin
        rdHigh <= !rdHigh;
        if (latchPend && rdHigh)
          latchPend <= 1'b0;
      end
    end
  end

  // R10: error flag never clears outside reset
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError);
  // R2/R3: each data write flips the write pointer
  p_wptr_toggle_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrData |=> (wrHigh != $past(wrHigh)));
  // R7: a pending snapshot survives anything but a read
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (latchPend && !rdData) |=> latchPend);
endmodule

// File: rtl/itc_datapath.sv
module itc_datapath
  import itc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [BYTE_W-1:0] wrByte,
  input  itc_strobe_t       strb,
  input  itc_mode_e         mode,
  output logic [BYTE_W-1:0] rdByte,
  output logic              timerOut
);
  logic [CNT_W-1:0] count, period, hold, loadVal, srcVal;
  logic             running, expire;

  assign loadVal = {wrByte, count[BYTE_W-1:0]};
  assign expire  = running && tickEn && (count == CNT_W'(1));
  assign srcVal  = strb.readHold ? hold : count;
  assign rdByte  = strb.readHigh ? srcVal[CNT_W-1:BYTE_W] : srcVal[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      period   <= '0;
      hold     <= '0;
      running  <= 1'b0;
      timerOut <= 1'b0;
    end else begin
      if (strb.snap)
        hold <= count;
      if (strb.loadLo) begin
        count[BYTE_W-1:0] <= wrByte;
        running  <= 1'b0;
        timerOut <= 1'b0;
      end else if (strb.loadHi) begin
        count   <= loadVal;
        period  <= loadVal;
        running <= (loadVal != '0);
      end else if (expire) begin
        if (mode == MODE_TC) begin
          count    <= '0;
          running  <= 1'b0;
          timerOut <= 1'b1;
        end else begin
          count <= period;
        end
      end else if (running && tickEn) begin
        count <= count - CNT_W'(1);
      end
    end
  end

  // R4: one step down per tick
  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (running && tickEn && !strb.loadLo && !strb.loadHi && count > CNT_W'(1))
    |=> (count == $past(count) - CNT_W'(1)));
  // R4: no tick, no load -> count holds
  p_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strb.loadLo && !strb.loadHi) |=> $stable(count));
  // R2: low-byte write stops and lowers
  p_lo_stop_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLo |=> (!running && !timerOut));
  // R5: output only rises at mode-0 terminal count
  p_tc_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerOut) |-> (mode == MODE_TC && count == '0));
  // R6: periodic modes reload on expiry
  p_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (expire && mode != MODE_TC && !strb.loadLo && !strb.loadHi)
    |=> (count == $past(period) && $stable(timerOut)));
endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan
  import itc_pkg::*;
#(
  parameter int CHAN_ID  = 0,
  parameter int SPKR_BIT = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       wrCtrl,
  input  logic       wrData,
  input  logic       rdData,
  input  logic [7:0] wrByte,
  output logic [7:0] rdByte,
  output logic       timerOut,
  output logic [7:0] portBStatus,
  output logic       cfgError
);
  itc_strobe_t strb;
  itc_mode_e   mode;

  itc_ctrl #(.CHAN_ID(CHAN_ID)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrCtrl(wrCtrl), .wrData(wrData),
    .rdData(rdData), .wrByte(wrByte), .strb(strb), .mode(mode),
    .cfgError(cfgError)
  );

  itc_datapath i_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrByte(wrByte),
    .strb(strb), .mode(mode), .rdByte(rdByte), .timerOut(timerOut)
  );

  always_comb begin
    portBStatus           = '0;
    portBStatus[SPKR_BIT] = timerOut;
  end
endmodule

// File: tb/test_interval_timer_chan.sv
module test_interval_timer_chan;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0, wrCtrl = 1'b0, wrData = 1'b0, rdData = 1'b0;
  logic [7:0] wrByte = '0;
  logic [7:0] rdByte, portBStatus;
  logic       timerOut, cfgError;

  interval_timer_chan #(.CHAN_ID(1), .SPKR_BIT(5)) i_interval_timer_chan (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrCtrl(wrCtrl),
    .wrData(wrData), .rdData(rdData), .wrByte(wrByte), .rdByte(rdByte),
    .timerOut(timerOut), .portBStatus(portBStatus), .cfgError(cfgError)
  );

  always #4 clk = ~clk;

  typedef struct {
    int         kind;   // 0 rdByte, 1 timerOut, 2 cfgError, 3 portBStatus
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    nChecks = 0;
  int    nFail   = 0;
  bit    finished = 0;

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = rdByte;
          1: act = {7'd0, timerOut};
          2: act = {7'd0, cfgError};
          default: act = portBStatus;
        endcase
        nChecks++;
        if (act !== it.exp) begin
          nFail++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic release_all();
    @(posedge clk);
    #1;
    wrCtrl = 0; wrData = 0; rdData = 0; tickEn = 0;
  endtask

  task automatic ctrl(input logic [7:0] b);
    @(negedge clk); wrCtrl = 1; wrByte = b;
    release_all();
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wrData = 1; wrByte = b;
    release_all();
  endtask

  task automatic load(input logic [15:0] v);
    wr(v[7:0]);
    wr(v[15:8]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1;
      release_all();
    end
  endtask

  task automatic rd(input logic [7:0] e, input string tag);
    @(negedge clk); rdData = 1;
    q.push_back('{0, e, tag});
    release_all();
  endtask

  task automatic chk(input int kind, input logic [7:0] e, input string tag);
    @(negedge clk);
    q.push_back('{kind, e, tag});
  endtask

  task automatic do_reset();
    @(negedge clk); rstN = 0;
    @(negedge clk); @(negedge clk); rstN = 1;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(1, 8'h00, "R1 out");
    chk(2, 8'h00, "R1 err");
    chk(3, 8'h00, "R1 portB");
    rd(8'h00, "R1 rd lo");
    rd(8'h00, "R1 rd hi");

    // mode 0, count 5
    ctrl(8'h70);
    load(16'h0005);
    rd(8'h05, "R9 live lo");
    rd(8'h00, "R9 live hi");
    ticks(4);
    rd(8'h01, "R4 lo after 4");
    rd(8'h00, "R4 hi after 4");
    chk(1, 8'h00, "R5 out before tc");
    ticks(1);
    chk(1, 8'h01, "R5 out at tc");
    chk(3, 8'h20, "R11 portB speaker");
    ticks(3);
    rd(8'h00, "R5 stays zero lo");
    rd(8'h00, "R5 stays zero hi");

    // R2 low byte stops countdown
    wr(8'h34);
    chk(1, 8'h00, "R2 out low");
    chk(3, 8'h00, "R11 portB low");
    ticks(3);
    rd(8'h34, "R2 stopped lo");
    rd(8'h00, "R2 stopped hi");
    wr(8'h12);
    rd(8'h34, "R3 loaded lo");
    rd(8'h12, "R3 loaded hi");
    ticks(2);
    // R7 latch then second latch ignored
    ctrl(8'h40);
    ticks(3);
    ctrl(8'h40);
    rd(8'h32, "R8 held lo");
    ticks(1);
    rd(8'h12, "R8 held hi");
    rd(8'h2E, "R9 live after release lo");
    // read pointer now high; latch resets it
    ticks(1);
    ctrl(8'h40);
    ticks(1);
    rd(8'h2D, "R7 ptr reset lo");
    rd(8'h12, "R7 held hi");
    rd(8'h2C, "R9 live lo");
    rd(8'h12, "R9 live hi");

    // R3 zero period does not count
    load(16'h0000);
    ticks(3);
    rd(8'h00, "R3 zero lo");
    rd(8'h00, "R3 zero hi");
    chk(1, 8'h00, "R3 zero no expiry");

    // R6 mode 2
    ctrl(8'h74);
    load(16'h0003);
    ticks(3);
    rd(8'h03, "R6 rate reload lo");
    rd(8'h00, "R6 rate reload hi");
    chk(1, 8'h00, "R6 rate out");
    ticks(1);
    rd(8'h02, "R6 rate step lo");
    rd(8'h00, "R6 rate step hi");

    // R6 mode 3
    ctrl(8'h76);
    load(16'h0002);
    ticks(2);
    rd(8'h02, "R6 sqw reload lo");
    rd(8'h00, "R6 sqw reload hi");
    chk(1, 8'h00, "R6 sqw out");

    // R10 errors
    do_reset();
    ctrl(8'h32);
    chk(2, 8'h00, "R10 foreign word ignored");
    ctrl(8'h70);
    ctrl(8'h75);
    chk(2, 8'h01, "R10 bcd error");
    load(16'h0002);
    ticks(2);
    chk(1, 8'h01, "R10 mode kept after bad word");
    do_reset();
    ctrl(8'hC0);
    chk(2, 8'h01, "R10 readback error");
    do_reset();
    ctrl(8'h50);
    chk(2, 8'h01, "R10 access error");
    do_reset();
    ctrl(8'h72);
    chk(2, 8'h01, "R10 mode1 error");
    do_reset();
    ctrl(8'h7C);
    chk(2, 8'h01, "R10 mode6 error");

    @(negedge clk);
    @(negedge clk);
    #2;
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule